// File: doc/BRIEF.md
# I2C Address-Phase Status Flag Tracker

This block watches an I2C bus that is sampled on a fast system clock. It synchronizes SCL and SDA and finds start and stop conditions. After each start it shifts in the first byte on the SCL rising edges. When the eighth rising edge arrives, it evaluates that byte once and updates three status flags:

- **Extension code seen:** the top four address bits are all zeros or all ones.
- **Own address matched:** the seven address bits equal the programmed local address.
- **Transmitting:** the direction flag.

In slave mode the direction flag comes from the received direction bit. In master mode it comes from the bit the master drives in that position.

Each flag has its own clear events:

- Bus conditions: a detected start, a detected stop, or a start the master generates.
- Control pulses: release and lost arbitration.
- A wait release, which is taken only during the ninth-clock wait.

The SDA output enable follows the direction flag. It is armed from the falling edge of the first byte's ninth SCL clock onwards. Generating SCL, arbitration, data transfer, acknowledge and clock stretching all stay outside the block.

Top module: `i2c_addr_status`

## Requirements
- R1: After reset, extCode, addrMatch, xmitDir and sdaOe are all 0.
- R2: A stop condition (SDA rising while SCL is high) clears extCode, addrMatch and xmitDir. A start condition is SDA falling while SCL is high.
- R3: extCode sets at the eighth SCL rising edge after a start when the first four received bits (bits 7..4 of the first byte, MSB first) are 0000 or 1111.
- R4: addrMatch sets at the eighth SCL rising edge when the first seven received bits (MSB first) equal localAddr.
- R5: In slave mode (masterMode=0), xmitDir sets at the eighth rising edge when the eighth received bit (the direction bit) is 1.
- R6: In master mode (masterMode=1), xmitDir takes masterDirBit at the eighth rising edge instead of the line value.
- R7: Only the first byte after a start is evaluated. Later bytes leave the flags unchanged.
- R8: A detected start clears extCode and addrMatch. It clears xmitDir only in slave mode. In master mode, a masterStart pulse clears xmitDir.
- R9: A releasePulse clears all three flags.
- R10: While enable is 0, every flag stays 0 and bus activity is ignored.
- R11: A 0-to-1 transition of lostArb clears xmitDir.
- R12: A waitRelease pulse clears xmitDir and sdaOe only while ninthWait is 1. Without ninthWait it has no effect.
- R13: sdaOe is 1 only when xmitDir is 1 and the falling edge of the first byte's ninth SCL clock has passed since the last start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Block enable; 0 clears flags and ignores the bus |
| sclIn | input | 1 | Raw SCL line sample |
| sdaIn | input | 1 | Raw SDA line sample |
| localAddr | input | 7 | Programmed own slave address |
| masterMode | input | 1 | 1 selects the master direction path |
| masterDirBit | input | 1 | Direction bit the master drives in the first byte |
| masterStart | input | 1 | Pulse: the master generated a start |
| lostArb | input | 1 | Lost-arbitration flag (its rising edge is used) |
| releasePulse | input | 1 | Pulse: release from the bus |
| waitRelease | input | 1 | Pulse: release of the wait state |
| ninthWait | input | 1 | High while the ninth-clock wait is active |
| extCode | output | 1 | Extension code received |
| addrMatch | output | 1 | Received address equals localAddr |
| xmitDir | output | 1 | Transmit direction flag |
| sdaOe | output | 1 | SDA output-driver enable |

## Verification
The bench builds the block with its defaults: a 7-bit address, a 4-bit extension field and two synchronizer stages.

At that size a full sweep becomes practical. It drives all 128 addresses with both direction bits against one fixed local address. It then holds one received address and sweeps all 128 local addresses. Together these cover every extension-code and match combination.

Directed sequences then cover the clear events: repeated start, release, wait release, lost arbitration, master start and disable. They also check the master direction path and the rule that only the first byte is evaluated.

// File: rtl/i2c_addr_status_pkg.sv
package i2c_addr_status_pkg;

  // Strobes from the bus control to the flag datapath, one cycle each
  typedef struct packed {
    logic busStart;   // start condition seen on the bus
    logic busStop;    // stop condition seen on the bus
    logic shiftEn;    // capture sdaBit into the address shifter
    logic evalAddr;   // eighth rising edge of the first byte
    logic ninthFall;  // falling edge of the first byte's ninth clock
    logic sdaBit;     // synchronized SDA level
  } strobe_t;

endpackage

// File: rtl/i2c_addr_status_sync.sv
module i2c_addr_status_sync #(
  parameter int STAGES = 2,
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '1;  // idle bus is high
    end else begin
      stg[0] <= din;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign dout = stg[STAGES-1];

endmodule

// File: rtl/i2c_addr_status_ctrl.sv
module i2c_addr_status_ctrl
  import i2c_addr_status_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int BYTE_BITS = 8
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    enable,
  input  logic    sclRaw,
  input  logic    sdaRaw,
  output strobe_t strb
);

  localparam int CNT_W = $clog2(BYTE_BITS + 2);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_BITS - 1);
  localparam logic [CNT_W-1:0] BYTE_END = CNT_W'(BYTE_BITS);
  localparam logic [CNT_W-1:0] ACK_BIT  = CNT_W'(BYTE_BITS + 1);

  typedef enum logic [1:0] {PH_IDLE, PH_ADDR, PH_DONE} phase_t;

  logic [1:0] lineSync;
  logic sclS, sdaS, sclD, sdaD;
  logic sclRise, sclFall, startDet, stopDet;
  phase_t phase;
  logic [CNT_W-1:0] edgeCnt;

  i2c_addr_status_sync #(.STAGES(SYNC_STAGES), .W(2)) u_sync (
    .clk (clk),
    .rstN(rstN),
    .din ({sclRaw, sdaRaw}),
    .dout(lineSync)
  );

  assign sclS = lineSync[1];
  assign sdaS = lineSync[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclD <= 1'b1;
      sdaD <= 1'b1;
    end else begin
      sclD <= sclS;
      sdaD <= sdaS;
    end
  end

  assign sclRise  = sclS & ~sclD;
  assign sclFall  = ~sclS & sclD;
  assign startDet = sclS & sclD & sdaD & ~sdaS;
  assign stopDet  = sclS & sclD & ~sdaD & sdaS;

  // Edge counter: counts rising edges of the first byte and its ack clock
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= PH_IDLE;
      edgeCnt <= '0;
    end else if (!enable) begin
      phase   <= PH_IDLE;
      edgeCnt <= '0;
    end else if (startDet) begin
      phase   <= PH_ADDR;
      edgeCnt <= '0;
    end else if (stopDet) begin
      phase   <= PH_IDLE;
      edgeCnt <= '0;
    end else if (phase == PH_ADDR) begin
      if (sclRise && edgeCnt < ACK_BIT) edgeCnt <= edgeCnt + 1'b1;
      if (sclFall && edgeCnt == ACK_BIT) phase <= PH_DONE;
    end
  end

  always_comb begin
    strb           = '0;
    strb.busStart  = enable & startDet;
    strb.busStop   = enable & stopDet;
    strb.shiftEn   = enable && phase == PH_ADDR && sclRise && edgeCnt < BYTE_END;
    strb.evalAddr  = strb.shiftEn && edgeCnt == LAST_BIT;
    strb.ninthFall = enable && phase == PH_ADDR && sclFall && edgeCnt == ACK_BIT;
    strb.sdaBit    = sdaS;
  end

  AST_START_RESTARTS_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    strb.busStart |=> !strb.evalAddr);  // R8

endmodule

// File: rtl/i2c_addr_status_dp.sv
module i2c_addr_status_dp
  import i2c_addr_status_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int EXT_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  strobe_t           strb,
  input  logic [ADDR_W-1:0] localAddr,
  input  logic              masterMode,
  input  logic              masterDirBit,
  input  logic              masterStart,
  input  logic              lostArb,
  input  logic              releasePulse,
  input  logic              waitRelease,
  input  logic              ninthWait,
  output logic              extCode,
  output logic              addrMatch,
  output logic              xmitDir,
  output logic              sdaOe
);

  localparam int BYTE_BITS = ADDR_W + 1;

  logic [BYTE_BITS-2:0] shiftReg;
  logic [BYTE_BITS-1:0] rxByte;
  logic [EXT_W-1:0]     extField;
  logic                 extHit, matchHit, dirNext;
  logic                 lostArbD, lostRise;
  logic                 clrCommon, trcClr;
  logic                 oeArmed;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shiftReg <= '0;
    else if (strb.shiftEn) shiftReg <= {shiftReg[BYTE_BITS-3:0], strb.sdaBit};
  end

  assign rxByte   = {shiftReg, strb.sdaBit};
  assign extField = rxByte[BYTE_BITS-1 -: EXT_W];
  assign extHit   = (extField == '0) || (extField == '1);
  assign matchHit = rxByte[BYTE_BITS-1:1] == localAddr;
  assign dirNext  = masterMode ? masterDirBit : rxByte[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lostArbD <= 1'b0;
    else       lostArbD <= lostArb;
  end
  assign lostRise = lostArb & ~lostArbD;

  assign clrCommon = !enable || strb.busStop || releasePulse;
  assign trcClr = clrCommon || lostRise
               || (waitRelease && ninthWait && xmitDir)
               || (!masterMode && strb.busStart)
               || (masterMode && masterStart);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      extCode   <= 1'b0;
      addrMatch <= 1'b0;
    end else if (clrCommon || strb.busStart) begin
      extCode   <= 1'b0;
      addrMatch <= 1'b0;
    end else if (strb.evalAddr) begin
      extCode   <= extHit;
      addrMatch <= matchHit;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              xmitDir <= 1'b0;
    else if (trcClr)        xmitDir <= 1'b0;
    else if (strb.evalAddr) xmitDir <= dirNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                         oeArmed <= 1'b0;
    else if (!enable || strb.busStart || strb.busStop) oeArmed <= 1'b0;
    else if (strb.ninthFall)                           oeArmed <= 1'b1;
  end

  assign sdaOe = xmitDir & oeArmed;

  AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    strb.busStop |=> !extCode && !addrMatch && !xmitDir);  // R2
  AST_RELEASE_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    releasePulse |=> !extCode && !addrMatch && !xmitDir);  // R9
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !extCode && !addrMatch && !xmitDir && !sdaOe);  // R10
  AST_LOSTARB_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lostArb) |=> !xmitDir);  // R11
  AST_OE_AFTER_NINTH: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaOe) |-> $past(strb.ninthFall));  // R13

endmodule

// File: rtl/i2c_addr_status.sv
module i2c_addr_status
  import i2c_addr_status_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int EXT_W = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [ADDR_W-1:0] localAddr,
  input  logic              masterMode,
  input  logic              masterDirBit,
  input  logic              masterStart,
  input  logic              lostArb,
  input  logic              releasePulse,
  input  logic              waitRelease,
  input  logic              ninthWait,
  output logic              extCode,
  output logic              addrMatch,
  output logic              xmitDir,
  output logic              sdaOe
);

  localparam int BYTE_BITS = ADDR_W + 1;

  strobe_t strb;

  i2c_addr_status_ctrl #(.SYNC_STAGES(SYNC_STAGES), .BYTE_BITS(BYTE_BITS)) u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .enable(enable),
    .sclRaw(sclIn),
    .sdaRaw(sdaIn),
    .strb  (strb)
  );

  i2c_addr_status_dp #(.ADDR_W(ADDR_W), .EXT_W(EXT_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .enable      (enable),
    .strb        (strb),
    .localAddr   (localAddr),
    .masterMode  (masterMode),
    .masterDirBit(masterDirBit),
    .masterStart (masterStart),
    .lostArb     (lostArb),
    .releasePulse(releasePulse),
    .waitRelease (waitRelease),
    .ninthWait   (ninthWait),
    .extCode     (extCode),
    .addrMatch   (addrMatch),
    .xmitDir     (xmitDir),
    .sdaOe       (sdaOe)
  );

endmodule

// File: tb/i2c_addr_status_bench.sv
module i2c_addr_status_bench;

  localparam int Q = 4;  // clocks per bus phase

  logic clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  logic rstN, enable, scl, sda;
  logic [6:0] localAddr;
  logic masterMode, masterDirBit, masterStart, lostArb;
  logic releasePulse, waitRelease, ninthWait;
  logic extCode, addrMatch, xmitDir, sdaOe;

  int nChk = 0;
  int nFail = 0;

  i2c_addr_status u_i2c_addr_status (
    .clk(clk), .rstN(rstN), .enable(enable), .sclIn(scl), .sdaIn(sda),
    .localAddr(localAddr), .masterMode(masterMode), .masterDirBit(masterDirBit),
    .masterStart(masterStart), .lostArb(lostArb), .releasePulse(releasePulse),
    .waitRelease(waitRelease), .ninthWait(ninthWait),
    .extCode(extCode), .addrMatch(addrMatch), .xmitDir(xmitDir), .sdaOe(sdaOe)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  task automatic chkFlags(input string req, input logic e, input logic m, input logic t);
    chk(req, "extCode", extCode, e);
    chk(req, "addrMatch", addrMatch, m);
    chk(req, "xmitDir", xmitDir, t);
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busStart();
    sda = 1'b1; tick(Q); scl = 1'b1; tick(Q);
    sda = 1'b0; tick(Q); scl = 1'b0; tick(Q);
  endtask

  task automatic busStop();
    sda = 1'b0; tick(Q); scl = 1'b1; tick(Q);
    sda = 1'b1; tick(Q);
  endtask

  task automatic bitOut(input logic b);
    sda = b; tick(Q); scl = 1'b1; tick(2 * Q); scl = 1'b0; tick(Q);
  endtask

  task automatic byteOut(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) bitOut(b[i]);
  endtask

  task automatic ackClock();
    sda = 1'b0; tick(Q); scl = 1'b1; tick(2 * Q); scl = 1'b0; tick(Q);
  endtask

  function automatic logic extOf(input logic [6:0] a);
    return (a[6:3] == 4'h0) || (a[6:3] == 4'hF);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    nChk++; nFail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    rstN = 1'b0; enable = 1'b1; scl = 1'b1; sda = 1'b1; localAddr = 7'h2A;
    masterMode = 1'b0; masterDirBit = 1'b0; masterStart = 1'b0; lostArb = 1'b0;
    releasePulse = 1'b0; waitRelease = 1'b0; ninthWait = 1'b0;
    tick(3);
    chkFlags("R1", 1'b0, 1'b0, 1'b0);
    chk("R1", "sdaOe", sdaOe, 1'b0);
    rstN = 1'b1;
    tick(3);
    chkFlags("R1", 1'b0, 1'b0, 1'b0);

    // Sweep every received address and direction bit against local 0x2A
    for (int a = 0; a < 128; a++) begin
      for (int d = 0; d < 2; d++) begin
        busStart();
        byteOut({a[6:0], d[0]});
        chk("R3", "extCode", extCode, extOf(a[6:0]));
        chk("R4", "addrMatch", addrMatch, a[6:0] == 7'h2A);
        chk("R5", "xmitDir", xmitDir, d[0]);
        chk("R13", "sdaOe before ninth", sdaOe, 1'b0);
        ackClock();
        chk("R13", "sdaOe after ninth", sdaOe, d[0]);
        busStop();
        chkFlags("R2", 1'b0, 1'b0, 1'b0);
        chk("R2", "sdaOe", sdaOe, 1'b0);
      end
    end

    // Sweep every local address against received 0x2A (byte 0x54)
    for (int l = 0; l < 128; l++) begin
      localAddr = l[6:0];
      busStart();
      byteOut(8'h54);
      chk("R4", "addrMatch sweep", addrMatch, l[6:0] == 7'h2A);
      busStop();
    end
    localAddr = 7'h2A;

    // R7: a second byte is not evaluated; R8: a repeated start clears in slave mode
    busStart(); byteOut(8'h55); ackClock();
    byteOut(8'h00);
    chkFlags("R7", 1'b0, 1'b1, 1'b1);
    ackClock();
    busStart();
    chkFlags("R8", 1'b0, 1'b0, 1'b0);
    busStop();

    // R9: release clears all flags
    localAddr = 7'h78;
    busStart(); byteOut(8'hF1);
    chkFlags("R3", 1'b1, 1'b1, 1'b1);
    releasePulse = 1'b1; tick(1); releasePulse = 1'b0; tick(1);
    chkFlags("R9", 1'b0, 1'b0, 1'b0);
    busStop();
    localAddr = 7'h2A;

    // R12: wait release only acts while the ninth-clock wait is active
    busStart(); byteOut(8'h55); ackClock();
    chk("R13", "sdaOe armed", sdaOe, 1'b1);
    waitRelease = 1'b1; tick(1); waitRelease = 1'b0; tick(1);
    chk("R12", "xmitDir no wait", xmitDir, 1'b1);
    ninthWait = 1'b1;
    waitRelease = 1'b1; tick(1); waitRelease = 1'b0; tick(1);
    ninthWait = 1'b0;
    chk("R12", "xmitDir", xmitDir, 1'b0);
    chk("R12", "sdaOe", sdaOe, 1'b0);
    chk("R12", "addrMatch kept", addrMatch, 1'b1);
    busStop();

    // R11: lost arbitration rising edge clears direction
    busStart(); byteOut(8'h55);
    lostArb = 1'b1; tick(2);
    chk("R11", "xmitDir", xmitDir, 1'b0);
    chk("R11", "addrMatch kept", addrMatch, 1'b1);
    lostArb = 1'b0;
    busStop();

    // R6/R8: master direction path and its start rules
    masterMode = 1'b1; masterDirBit = 1'b1;
    busStart(); byteOut(8'h54);
    chk("R6", "xmitDir from master bit", xmitDir, 1'b1);
    ackClock();
    busStart();
    chk("R8", "master keeps dir on bus start", xmitDir, 1'b1);
    masterStart = 1'b1; tick(1); masterStart = 1'b0; tick(1);
    chk("R8", "masterStart clears dir", xmitDir, 1'b0);
    busStop();
    masterDirBit = 1'b0;
    busStart(); byteOut(8'h55);
    chk("R6", "xmitDir ignores line bit", xmitDir, 1'b0);
    busStop();
    masterMode = 1'b0;

    // R10: disable clears and ignores the bus
    busStart(); byteOut(8'h55);
    enable = 1'b0; tick(2);
    chkFlags("R10", 1'b0, 1'b0, 1'b0);
    busStop();
    busStart(); byteOut(8'h55); ackClock();
    chkFlags("R10", 1'b0, 1'b0, 1'b0);
    chk("R10", "sdaOe", sdaOe, 1'b0);
    enable = 1'b1;
    byteOut(8'h55);
    chkFlags("R10", 1'b0, 1'b0, 1'b0);
    busStop();

    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

endmodule